// File: doc/BRIEF.md
# Self-correcting Johnson decade counter

This block is a decade counter built on a five-stage twisted-ring (Johnson) register. The register walks through ten legal patterns, and each pattern is decoded onto one of ten active-high lines. An active-low carry comes straight from the top ring stage. It is low for the second half of the decade, so one counter can feed the rising-edge count input of the next.

Two level inputs control counting, and both are sampled by the system clock. A rising edge on the first input counts only while the second input is low. A falling edge on the second input counts only while the first input is high. Each input passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one clock earlier, and the counter moves at most one step per clock.

An asynchronous, active-high clear forces state 0. After the clear is released, a short warm-up keeps input levels that were already present from being taken as edges. If the ring ever holds a pattern outside the ten legal ones, the next count event loads state 0.

Top module: `johnson_decade`

## Requirements
- R1: The counter has ten states, 0 to 9. Each count event moves it from state k to state (k+1) mod 10. State k is held in the ring as the 5-bit pattern ring[4:0] = 2^k-1 for k ≤ 5 and 31 XOR (2^(k-5)-1) for k > 5.
- R2: `state_dec[k]` is high in state k, and exactly one bit of `state_dec` is high in any legal state.
- R3: A low-to-high change of `tick_pos` while `tick_neg` is low is one count event. It shows on the outputs within five clock cycles.
- R4: A high-to-low change of `tick_neg` while `tick_pos` is high is one count event.
- R5: These leave the state unchanged: a rise of `tick_pos` while `tick_neg` is high, a fall of `tick_pos`, a rise of `tick_neg`, a fall of `tick_neg` while `tick_pos` is low, and levels held on either input across the release of `clr`.
- R6: `carry_n` is low in states 5 to 9 and high in states 0 to 4.
- R7: While `clr` is high, the state is 0 (`state_dec` = 1, `carry_n` = 1) without waiting for a clock edge, whatever the count inputs do.
- R8: From any of the 22 illegal ring patterns, the first count event loads state 0. This is well inside a bound of 11 count events.
- R9: When a qualifying rise of `tick_pos` and a qualifying fall of `tick_neg` land in the same clock cycle, the counter advances by exactly one.
- R10: Two counters can be cascaded by driving the second `tick_pos` from the first `carry_n`, with the second `tick_neg` held low. The second counter then advances once each time the first wraps from 9 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the count inputs |
| clr | input | 1 | Asynchronous clear, active high |
| tick_pos | input | 1 | Count input, counts on a rise while `tick_neg` is low |
| tick_neg | input | 1 | Count input, counts on a fall while `tick_pos` is high |
| state_dec | output | 10 | One-hot decode of the current state |
| carry_n | output | 1 | Inverted top ring stage, low in states 5 to 9 |

## Verification
The assertions assume two things about the inputs. First, each level on the count inputs is held long enough to get through the synchronizer, so that every edge the design sees is a real one. Second, the ring changes only through a count event or `clr`, with the single exception of patterns written into it on purpose. The stimulus holds every input level for five clocks or more. It drives the inputs on falling clock edges, and it loads illegal ring patterns only between count events, so each step and hold property compares two legal states. Across the release of `clr`, the input levels are held steady so that the warm-up window is exercised.

// File: rtl/johnson_decade.sv
`timescale 1ns/1ps
module johnson_decade (
  input  logic       clk,
  input  logic       clr,
  input  logic       tick_pos,
  input  logic       tick_neg,
  output logic [9:0] state_dec,
  output logic       carry_n
);

  logic [1:0] pos_sync, neg_sync;
  logic       pos_prev, neg_prev;
  logic [1:0] warm;
  logic [4:0] ring;
  logic       legal, adv, rise_hit, fall_hit;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      pos_sync <= '0;
      neg_sync <= '0;
      pos_prev <= 1'b0;
      neg_prev <= 1'b0;
      warm     <= '0;
    end else begin
      pos_sync <= {pos_sync[0], tick_pos};
      neg_sync <= {neg_sync[0], tick_neg};
      pos_prev <= pos_sync[1];
      neg_prev <= neg_sync[1];
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign rise_hit = pos_sync[1] & ~pos_prev & ~neg_sync[1];
  assign fall_hit = neg_prev & ~neg_sync[1] & pos_sync[1];
  assign adv      = (warm == 2'd3) & (rise_hit | fall_hit);

  function automatic logic ring_ok(input logic [4:0] r);
    logic [4:0] d;
    int n;
    d = r ^ {r[3:0], ~r[4]};
    n = 0;
    for (int i = 0; i < 5; i++) n += 32'(d[i]);
    return n == 1;
  endfunction

  assign legal = ring_ok(ring);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)      ring <= '0;
    else if (adv) ring <= legal ? {ring[3:0], ~ring[4]} : 5'd0;
  end

  always_comb begin
    state_dec[0] = ~ring[4] & ~ring[0];
    state_dec[5] =  ring[4] &  ring[0];
    for (int k = 1; k < 5; k++) begin
      state_dec[k]     =  ring[k-1] & ~ring[k];
      state_dec[k + 5] = ~ring[k-1] &  ring[k];
    end
  end

  assign carry_n = ~ring[4];

  assert_step_R1: assert property (@(posedge clk) disable iff (clr)
    legal && adv |=> state_dec == {$past(state_dec[8:0]), $past(state_dec[9])});

  assert_onehot_R2: assert property (@(posedge clk) disable iff (clr)
    legal |-> $countones(state_dec) == 1);

  assert_hold_R5: assert property (@(posedge clk) disable iff (clr)
    legal && !adv |=> $stable(state_dec) || !legal);

  assert_carry_R6: assert property (@(posedge clk) disable iff (clr)
    legal |-> carry_n == !(|state_dec[9:5]));

  assert_clear_R7: assert property (@(posedge clk)
    clr |-> state_dec == 10'd1 && carry_n);

  assert_recover_R8: assert property (@(posedge clk) disable iff (clr)
    !legal && adv |=> state_dec == 10'd1);

endmodule

// File: tb/johnson_decade_tb_top.sv
`timescale 1ns/1ps
module johnson_decade_tb_top;
  logic clk = 1'b0;
  logic clr = 1'b1;
  logic tick_pos = 1'b0;
  logic tick_neg = 1'b0;
  logic [9:0] dec_a, dec_b;
  logic carry_a, carry_b;
  int total = 0;
  int bad = 0;
  int st = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  johnson_decade dut_i (.clk(clk), .clr(clr), .tick_pos(tick_pos), .tick_neg(tick_neg),
                        .state_dec(dec_a), .carry_n(carry_a));
  johnson_decade casc_i (.clk(clk), .clr(clr), .tick_pos(carry_a), .tick_neg(1'b0),
                         .state_dec(dec_b), .carry_n(carry_b));

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [10:0] act, input int exp);
    logic [10:0] want;
    want = {exp < 5 ? 1'b1 : 1'b0, 10'(10'd1 << exp)};
    total++;
    if (act !== want) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, want);
    end
  endtask

  task automatic step_pos();
    tick_pos = 1'b1; wait_n(5);
    tick_pos = 1'b0; wait_n(5);
    st = (st + 1) % 10;
  endtask

  function automatic bit is_legal(input int p);
    for (int k = 0; k < 10; k++)
      if (p == (k <= 5 ? (1 << k) - 1 : 31 ^ ((1 << (k - 5)) - 1))) return 1;
    return 0;
  endfunction

  initial begin
    #12;
    chk("R7 reset state", {carry_a, dec_a}, 0);
    chk("R7 reset state cascade", {carry_b, dec_b}, 0);
    @(negedge clk); clr = 1'b0; wait_n(6);

    for (int n = 1; n <= 25; n++) begin
      step_pos();
      chk("R1 R2 R3 R6 rising count", {carry_a, dec_a}, st);
      chk("R10 cascade", {carry_b, dec_b}, n / 10);
    end

    for (int n = 0; n < 3; n++) begin
      tick_neg = 1'b1; wait_n(5);
      chk("R5 neg rise ignored", {carry_a, dec_a}, st);
      tick_pos = 1'b1; wait_n(5);
      chk("R5 pos rise with neg high ignored", {carry_a, dec_a}, st);
      tick_neg = 1'b0; wait_n(5);
      st = (st + 1) % 10;
      chk("R4 falling count", {carry_a, dec_a}, st);
      tick_pos = 1'b0; wait_n(5);
      chk("R5 pos fall ignored", {carry_a, dec_a}, st);
    end

    tick_neg = 1'b1; wait_n(5);
    tick_pos = 1'b1; tick_neg = 1'b0; wait_n(6);
    st = (st + 1) % 10;
    chk("R9 coincident edges count once", {carry_a, dec_a}, st);
    tick_pos = 1'b0; wait_n(5);

    tick_neg = 1'b1; wait_n(5);
    tick_neg = 1'b0; wait_n(5);
    chk("R5 neg fall with pos low ignored", {carry_a, dec_a}, st);

    step_pos(); step_pos();
    #1 clr = 1'b1; tick_pos = 1'b1; tick_neg = 1'b1;
    #1 chk("R7 async clear", {carry_a, dec_a}, 0);
    st = 0;
    wait_n(3);
    tick_neg = 1'b0; wait_n(2);
    chk("R7 clear overrides inputs", {carry_a, dec_a}, 0);
    tick_neg = 1'b1; wait_n(1);
    clr = 1'b0; wait_n(8);
    chk("R5 held levels across clear release", {carry_a, dec_a}, 0);
    tick_pos = 1'b0; wait_n(5);
    tick_neg = 1'b0; wait_n(5);
    chk("R5 settle after release", {carry_a, dec_a}, 0);

    for (int p = 0; p < 32; p++) begin
      if (!is_legal(p)) begin
        @(negedge clk);
        force dut_i.ring = 5'(p);
        #1 release dut_i.ring;
        wait_n(2);
        step_pos();
        st = 0;
        chk("R8 illegal pattern recovers", {carry_a, dec_a}, 0);
      end
    end
    step_pos();
    chk("R8 counting resumes", {carry_a, dec_a}, st);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule